// File: doc/BRIEF.md
# Exception Vector Entry Controller

This block decides when a 64-bit core takes an exception, which handler it jumps to, and what state it saves. It watches a one-cycle synchronous-fault strobe that carries the faulting PC. It also watches three level-sensitive asynchronous request lines: normal interrupt, fast interrupt and system error. The core supplies its current PC and condition flags every cycle. The block itself holds the exception level, the stack-select bit and the three asynchronous mask bits, and it drives them out to the core.

When an exception is taken, the block works out the target level. It picks one of sixteen 128-byte handler slots above a per-level vector base, saves the status word and the return address into the target level's banked registers, masks all asynchronous classes and selects the target level's own stack. A return-from-exception command undoes this in one cycle: state comes back from the saved-status register and the PC from the link register. A small register port lets software program the vector bases and read or rewrite the banked saved-status and link registers.

The redirect output is a strobe. It has no valid/ready handshake and no back-pressure: the core must follow a redirect in the cycle it appears. All inputs are plain control pins.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the level is RST_EL (default 1), `sp_sel` is 1, `exc_mask` is 3'b111 and `redirect` is 0.
- R2: Taking an exception in cycle N gives `redirect`=1 and `redir_ret`=0 in cycle N+1 only. In that cycle `redir_pc` equals the target level's vector base plus 0x200 times the group plus 0x80 times the class, so its low 7 bits are zero.
- R3: The class codes are sync=0, IRQ=1, FIQ=2, SError=3. The group codes are: same level on stack 0 = 0, same level on its own stack = 1, lower level in 64-bit state = 2, lower level in 32-bit state = 3 (`lower_aa32`=1). `redir_vec` equals group*4 + class.
- R4: The vector base register of each level reads with bits [10:0] as zero. Writes to those bits are ignored.
- R5: The target level is 1 when the current level is 0 and is otherwise the current level, so it is never lower.
- R6: On entry, the target level's saved-status register receives the status word from before entry. Its layout is flags[9:6], SError mask[5], FIQ mask[4], IRQ mask[3], stack select[2], level[1:0].
- R7: The saved return address is `fault_pc` for a synchronous exception and `cur_pc` for an asynchronous one.
- R8: Entry sets `exc_mask` (bit 2 SError, bit 1 FIQ, bit 0 IRQ) to 3'b111, sets `sp_sel` to 1 and sets the level to the target.
- R9: An asynchronous request whose mask bit is 1 is not taken. There is no redirect and the level, stack select and masks stay unchanged.
- R10: The fixed priority is sync fault, then SError, then FIQ, then IRQ, then the return command. A return command that loses to an exception is dropped.
- R11: A return command at level 1 or above restores level, stack select and masks from that level's saved-status register. The next cycle shows `redirect`=1, `redir_ret`=1 and `redir_pc` equal to that level's link register.
- R12: A return command at level 0 is ignored: no redirect, and the level stays 0.
- R13: Register port: `sys_sel` 0 selects the vector base, 1 the link register and 2 the saved status, for the level on `sys_el`. A write takes effect at the clock edge and `sys_rdata` reads combinationally. Level 0 has no bank and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_flt | input | 1 | One-cycle synchronous fault strobe |
| fault_pc | input | ADDR_W | Address of the faulting instruction |
| irq_req | input | 1 | Normal interrupt request, level |
| fiq_req | input | 1 | Fast interrupt request, level |
| serr_req | input | 1 | System error request, level |
| eret_req | input | 1 | Return-from-exception command strobe |
| cur_pc | input | ADDR_W | First instruction not yet completed |
| cond_flags | input | 4 | Core condition flags for the saved status |
| lower_aa32 | input | 1 | Lower level runs in 32-bit state |
| sys_we | input | 1 | Register port write enable |
| sys_sel | input | 2 | Register select: 0 base, 1 link, 2 status |
| sys_el | input | 2 | Level whose bank is accessed |
| sys_wdata | input | ADDR_W | Register port write data |
| sys_rdata | output | ADDR_W | Register port read data |
| redirect | output | 1 | One-cycle PC redirect strobe |
| redir_pc | output | ADDR_W | New PC |
| redir_vec | output | 4 | Taken slot index, group*4+class |
| redir_ret | output | 1 | Redirect comes from a return |
| cur_el | output | 2 | Current exception level |
| sp_sel | output | 1 | Stack select |
| exc_mask | output | 3 | Masks {SError, FIQ, IRQ} |

## Verification
The assertions assume that `sync_flt` only pulses when the core actually has a faulting instruction. They also assume that software never loads a saved-status level at or above NUM_EL, and that a register-port write never targets the bank that an entry is writing in the same cycle. The stimulus respects all three. Every level change goes through the return command with a saved status built from legal fields. Asynchronous lines are dropped in the cycle the redirect appears, and the register port is only driven while no exception line is active. Under these rules, the masking and priority properties check the arbitration outcome directly against the input lines.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int MAX_EL    = 4;
  localparam int VBAR_LSB  = 11;
  localparam int SLOT_LSB  = 7;

  typedef enum logic [1:0] {
    CLS_SYNC = 2'd0,
    CLS_IRQ  = 2'd1,
    CLS_FIQ  = 2'd2,
    CLS_SERR = 2'd3
  } exc_cls_e;

  typedef enum logic [1:0] {
    GRP_CUR_SP0 = 2'd0,
    GRP_CUR_SPX = 2'd1,
    GRP_LOW_A64 = 2'd2,
    GRP_LOW_A32 = 2'd3
  } exc_grp_e;

  typedef enum logic [1:0] {
    SR_VBAR = 2'd0,
    SR_ELR  = 2'd1,
    SR_SPSR = 2'd2
  } sysreg_e;

  typedef struct packed {
    logic [3:0] flags;
    logic       m_serr;
    logic       m_fiq;
    logic       m_irq;
    logic       spsel;
    logic [1:0] el;
  } status_t;

  localparam int SW = $bits(status_t);
endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  logic     sync_flt,
  input  logic     irq_req,
  input  logic     fiq_req,
  input  logic     serr_req,
  input  logic     eret_req,
  input  logic [2:0] mask,
  input  logic [1:0] cur_el,
  output logic     take,
  output exc_cls_e cls,
  output logic     do_ret
);
  // fixed order: fault, system error, fast, normal, then return
  always_comb begin
    take   = 1'b0;
    cls    = CLS_SYNC;
    do_ret = 1'b0;
    if (sync_flt) begin
      take = 1'b1;
      cls  = CLS_SYNC;
    end else if (serr_req && !mask[2]) begin
      take = 1'b1;
      cls  = CLS_SERR;
    end else if (fiq_req && !mask[1]) begin
      take = 1'b1;
      cls  = CLS_FIQ;
    end else if (irq_req && !mask[0]) begin
      take = 1'b1;
      cls  = CLS_IRQ;
    end else if (eret_req && cur_el != 2'd0) begin
      do_ret = 1'b1;
    end
  end
endmodule

// File: rtl/exc_vecgen.sv
module exc_vecgen
  import exc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [1:0]        cur_el,
  input  logic              spsel,
  input  logic              lower_aa32,
  input  exc_cls_e          cls,
  input  logic [ADDR_W-1:0] vbar_t,
  output logic [1:0]        tgt_el,
  output exc_grp_e          grp,
  output logic [3:0]        vec_idx,
  output logic [ADDR_W-1:0] handler
);
  localparam int OFS_W = VBAR_LSB;

  logic [OFS_W-1:0] ofs;

  // level 0 never handles its own exceptions
  assign tgt_el = (cur_el == 2'd0) ? 2'd1 : cur_el;

  always_comb begin
    if (tgt_el != cur_el)
      grp = lower_aa32 ? GRP_LOW_A32 : GRP_LOW_A64;
    else
      grp = spsel ? GRP_CUR_SPX : GRP_CUR_SP0;
  end

  assign vec_idx = {grp, cls};
  assign ofs     = {grp, cls, {SLOT_LSB{1'b0}}};
  assign handler = vbar_t + ADDR_W'(ofs);
endmodule

// File: rtl/exc_sysregs.sv
module exc_sysregs
  import exc_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int NUM_EL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_we,
  input  logic [1:0]        sys_sel,
  input  logic [1:0]        sys_el,
  input  logic [ADDR_W-1:0] sys_wdata,
  output logic [ADDR_W-1:0] sys_rdata,
  input  logic              ent_we,
  input  logic [1:0]        ent_el,
  input  status_t           ent_spsr,
  input  logic [ADDR_W-1:0] ent_elr,
  input  logic [1:0]        tgt_el,
  input  logic [1:0]        cur_el,
  output logic [ADDR_W-1:0] vbar_tgt,
  output status_t           spsr_cur,
  output logic [ADDR_W-1:0] elr_cur
);
  localparam int HI_W = ADDR_W - VBAR_LSB;

  logic [HI_W-1:0]   vbar_hi [MAX_EL];
  logic [ADDR_W-1:0] elr_r   [MAX_EL];
  status_t           spsr_r  [MAX_EL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_EL; i++) begin
        vbar_hi[i] <= '0;
        elr_r[i]   <= '0;
        spsr_r[i]  <= '0;
      end
    end else begin
      for (int lv = 1; lv < NUM_EL; lv++) begin
        if (sys_we && sys_el == 2'(lv) && sys_sel == SR_VBAR)
          vbar_hi[lv] <= sys_wdata[ADDR_W-1:VBAR_LSB];
        if (ent_we && ent_el == 2'(lv)) begin
          spsr_r[lv] <= ent_spsr;
          elr_r[lv]  <= ent_elr;
        end else if (sys_we && sys_el == 2'(lv)) begin
          if (sys_sel == SR_ELR)  elr_r[lv]  <= sys_wdata;
          if (sys_sel == SR_SPSR) spsr_r[lv] <= status_t'(sys_wdata[SW-1:0]);
        end
      end
    end
  end

  always_comb begin
    case (sys_sel)
      SR_VBAR: sys_rdata = {vbar_hi[sys_el], {VBAR_LSB{1'b0}}};
      SR_ELR:  sys_rdata = elr_r[sys_el];
      SR_SPSR: sys_rdata = ADDR_W'(spsr_r[sys_el]);
      default: sys_rdata = '0;
    endcase
  end

  assign vbar_tgt = {vbar_hi[tgt_el], {VBAR_LSB{1'b0}}};
  assign spsr_cur = spsr_r[cur_el];
  assign elr_cur  = elr_r[cur_el];

  // R6
  entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_we |=> (spsr_r[$past(ent_el)] == $past(ent_spsr)) &&
               (elr_r[$past(ent_el)] == $past(ent_elr)));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int NUM_EL = 4,
  parameter int RST_EL = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_flt,
  input  logic [ADDR_W-1:0] fault_pc,
  input  logic              irq_req,
  input  logic              fiq_req,
  input  logic              serr_req,
  input  logic              eret_req,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [3:0]        cond_flags,
  input  logic              lower_aa32,
  input  logic              sys_we,
  input  logic [1:0]        sys_sel,
  input  logic [1:0]        sys_el,
  input  logic [ADDR_W-1:0] sys_wdata,
  output logic [ADDR_W-1:0] sys_rdata,
  output logic              redirect,
  output logic [ADDR_W-1:0] redir_pc,
  output logic [3:0]        redir_vec,
  output logic              redir_ret,
  output logic [1:0]        cur_el,
  output logic              sp_sel,
  output logic [2:0]        exc_mask
);
  logic [1:0] el_q;
  logic       spsel_q;
  logic [2:0] mask_q;

  logic              take, do_ret;
  exc_cls_e          cls;
  exc_grp_e          grp;
  logic [1:0]        tgt_el;
  logic [3:0]        vec_idx;
  logic [ADDR_W-1:0] handler, vbar_t, elr_cur, ret_addr;
  status_t           spsr_cur, cur_st;

  assign cur_st = '{flags: cond_flags, m_serr: mask_q[2], m_fiq: mask_q[1],
                    m_irq: mask_q[0], spsel: spsel_q, el: el_q};
  assign ret_addr = (cls == CLS_SYNC) ? fault_pc : cur_pc;

  exc_prio u_prio (
    .sync_flt (sync_flt),
    .irq_req  (irq_req),
    .fiq_req  (fiq_req),
    .serr_req (serr_req),
    .eret_req (eret_req),
    .mask     (mask_q),
    .cur_el   (el_q),
    .take     (take),
    .cls      (cls),
    .do_ret   (do_ret)
  );

  exc_vecgen #(.ADDR_W(ADDR_W)) u_vec (
    .cur_el     (el_q),
    .spsel      (spsel_q),
    .lower_aa32 (lower_aa32),
    .cls        (cls),
    .vbar_t     (vbar_t),
    .tgt_el     (tgt_el),
    .grp        (grp),
    .vec_idx    (vec_idx),
    .handler    (handler)
  );

  exc_sysregs #(.ADDR_W(ADDR_W), .NUM_EL(NUM_EL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_we    (sys_we),
    .sys_sel   (sys_sel),
    .sys_el    (sys_el),
    .sys_wdata (sys_wdata),
    .sys_rdata (sys_rdata),
    .ent_we    (take),
    .ent_el    (tgt_el),
    .ent_spsr  (cur_st),
    .ent_elr   (ret_addr),
    .tgt_el    (tgt_el),
    .cur_el    (el_q),
    .vbar_tgt  (vbar_t),
    .spsr_cur  (spsr_cur),
    .elr_cur   (elr_cur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      el_q      <= 2'(RST_EL);
      spsel_q   <= 1'b1;
      mask_q    <= 3'b111;
      redirect  <= 1'b0;
      redir_ret <= 1'b0;
      redir_pc  <= '0;
      redir_vec <= '0;
    end else begin
      redirect  <= 1'b0;
      redir_ret <= 1'b0;
      if (take) begin
        el_q      <= tgt_el;
        spsel_q   <= 1'b1;
        mask_q    <= 3'b111;
        redirect  <= 1'b1;
        redir_pc  <= handler;
        redir_vec <= vec_idx;
      end else if (do_ret) begin
        el_q      <= spsr_cur.el;
        spsel_q   <= spsr_cur.spsel;
        mask_q    <= {spsr_cur.m_serr, spsr_cur.m_fiq, spsr_cur.m_irq};
        redirect  <= 1'b1;
        redir_ret <= 1'b1;
        redir_pc  <= elr_cur;
        redir_vec <= '0;
      end
    end
  end

  assign cur_el   = el_q;
  assign sp_sel   = spsel_q;
  assign exc_mask = mask_q;

  // R2
  slot_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !redir_ret) |-> (redir_pc[SLOT_LSB-1:0] == '0));
  // R5
  tgt_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !redir_ret) |-> (cur_el != 2'd0) && (cur_el >= $past(cur_el)));
  // R8
  entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !redir_ret) |-> (exc_mask == 3'b111) && sp_sel);
  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_flt && !eret_req && exc_mask == 3'b111) |=> !redirect);
  // R10
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flt |=> redirect && !redir_ret && (redir_vec[1:0] == 2'd0));
endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_flt = 0, irq_req = 0, fiq_req = 0, serr_req = 0, eret_req = 0;
  logic [63:0] fault_pc = 0, cur_pc = 0, sys_wdata = 0;
  logic [3:0]  cond_flags = 0;
  logic        lower_aa32 = 0, sys_we = 0;
  logic [1:0]  sys_sel = 0, sys_el = 0;
  logic [63:0] sys_rdata, redir_pc;
  logic        redirect, redir_ret, sp_sel;
  logic [3:0]  redir_vec;
  logic [1:0]  cur_el;
  logic [2:0]  exc_mask;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sync_flt(sync_flt), .fault_pc(fault_pc),
    .irq_req(irq_req), .fiq_req(fiq_req), .serr_req(serr_req), .eret_req(eret_req),
    .cur_pc(cur_pc), .cond_flags(cond_flags), .lower_aa32(lower_aa32),
    .sys_we(sys_we), .sys_sel(sys_sel), .sys_el(sys_el), .sys_wdata(sys_wdata),
    .sys_rdata(sys_rdata), .redirect(redirect), .redir_pc(redir_pc),
    .redir_vec(redir_vec), .redir_ret(redir_ret), .cur_el(cur_el),
    .sp_sel(sp_sel), .exc_mask(exc_mask)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sysw(input logic [1:0] sel, input logic [1:0] el, input logic [63:0] d);
    sys_we = 1; sys_sel = sel; sys_el = el; sys_wdata = d;
    @(negedge clk);
    sys_we = 0;
  endtask

  task automatic sysr(input logic [1:0] sel, input logic [1:0] el, output logic [63:0] d);
    sys_sel = sel; sys_el = el;
    #1 d = sys_rdata;
  endtask

  function automatic logic [63:0] st(input logic [3:0] fl, input logic [2:0] m,
                                     input logic sp, input logic [1:0] el);
    return 64'((fl << 6) | (m << 3) | (sp << 2) | el);
  endfunction

  // return to a chosen level through the return command
  task automatic go_level(input logic [1:0] el, input logic sp, input logic [2:0] m,
                          input logic [63:0] pc);
    logic [1:0] k;
    k = cur_el;
    sysw(2'd2, k, st(4'd0, m, sp, el));
    sysw(2'd1, k, pc);
    eret_req = 1;
    @(negedge clk);
    eret_req = 0;
    chk("R11 redirect", 64'(redirect), 64'd1);
    chk("R11 redir_ret", 64'(redir_ret), 64'd1);
    chk("R11 pc", redir_pc, pc);
    chk("R11 level", 64'(cur_el), 64'(el));
    chk("R11 sp_sel", 64'(sp_sel), 64'(sp));
    chk("R11 mask", 64'(exc_mask), 64'(m));
  endtask

  task automatic expect_take(input string tag, input logic [63:0] pc, input logic [3:0] vec);
    chk({tag, " redirect"}, 64'(redirect), 64'd1);
    chk({tag, " redir_ret"}, 64'(redir_ret), 64'd0);
    chk({tag, " pc"}, redir_pc, pc);
    chk({tag, " vec"}, 64'(redir_vec), 64'(vec));
  endtask

  logic [63:0] vbs [3];
  logic [63:0] rd;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vbs[0] = 64'h0;
    vbs[1] = 64'h0000_0000_0008_0000;
    vbs[2] = 64'hFFFF_FFFF_FFFF_F800;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 redirect", 64'(redirect), 64'd0);
    chk("R1 level", 64'(cur_el), 64'd1);
    chk("R1 sp_sel", 64'(sp_sel), 64'd1);
    chk("R1 mask", 64'(exc_mask), 64'd7);
    rst_n = 1;
    @(negedge clk);

    // R4 low base bits ignored
    sysw(2'd0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    sysr(2'd0, 2'd1, rd);
    chk("R4 base align", rd, 64'hFFFF_FFFF_FFFF_F800);

    // R13 banks per level, level 0 absent
    sysw(2'd1, 2'd3, 64'h1234_5678_9ABC_DEF0);
    sysr(2'd1, 2'd3, rd);
    chk("R13 link bank 3", rd, 64'h1234_5678_9ABC_DEF0);
    sysw(2'd1, 2'd0, 64'hDEAD);
    sysr(2'd1, 2'd0, rd);
    chk("R13 level 0 bank", rd, 64'd0);

    // R2 R3 R5 R6 R7 R8: full sweep of 16 slots over three bases
    for (int v = 0; v < 3; v++) begin
      sysw(2'd0, 2'd1, vbs[v] | 64'h5A5);
      for (int g = 0; g < 4; g++) begin
        for (int c = 0; c < 4; c++) begin
          logic [63:0] fp, cp;
          logic [3:0]  fl;
          logic [1:0]  elb;
          logic        spb;
          fp  = 64'h0008_0000 + 64'((v * 16 + g * 4 + c) * 4);
          cp  = fp + 64'h1000;
          fl  = 4'(g * 4 + c + v);
          elb = (g < 2) ? 2'd1 : 2'd0;
          spb = (g == 1);
          go_level(elb, spb, 3'b000, 64'h100 + 64'(g));
          lower_aa32 = (g == 3);
          cond_flags = fl; cur_pc = cp; fault_pc = fp;
          case (c)
            0: sync_flt = 1;
            1: irq_req = 1;
            2: fiq_req = 1;
            default: serr_req = 1;
          endcase
          @(negedge clk);
          sync_flt = 0; irq_req = 0; fiq_req = 0; serr_req = 0;
          expect_take("R2 R3 slot", vbs[v] + 64'(g * 512 + c * 128), 4'(g * 4 + c));
          chk("R5 target level", 64'(cur_el), 64'd1);
          chk("R8 sp_sel", 64'(sp_sel), 64'd1);
          chk("R8 mask", 64'(exc_mask), 64'd7);
          sysr(2'd1, 2'd1, rd);
          chk("R7 return address", rd, (c == 0) ? fp : cp);
          sysr(2'd2, 2'd1, rd);
          chk("R6 saved status", rd, st(fl, 3'b000, spb, elb));
          @(negedge clk);
          chk("R2 one-cycle strobe", 64'(redirect), 64'd0);
        end
      end
    end
    lower_aa32 = 0;
    sysw(2'd0, 2'd1, 64'h0000_0000_0004_0000);

    // R9 all masked: nothing taken
    irq_req = 1; fiq_req = 1; serr_req = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 masked no redirect", 64'(redirect), 64'd0);
      chk("R9 masked level", 64'(cur_el), 64'd1);
    end
    irq_req = 0; fiq_req = 0; serr_req = 0;

    // R9 partial mask: IRQ masked, FIQ open
    go_level(2'd1, 1'b1, 3'b001, 64'h200);
    irq_req = 1;
    @(negedge clk);
    chk("R9 irq masked", 64'(redirect), 64'd0);
    chk("R9 mask kept", 64'(exc_mask), 64'd1);
    fiq_req = 1;
    @(negedge clk);
    irq_req = 0; fiq_req = 0;
    expect_take("R9 fiq open", 64'h0004_0000 + 64'h200 + 64'h100, 4'd6);

    // R10 priority ladder
    go_level(2'd1, 1'b1, 3'b000, 64'h300);
    sync_flt = 1; irq_req = 1; fiq_req = 1; serr_req = 1;
    @(negedge clk);
    sync_flt = 0; irq_req = 0; fiq_req = 0; serr_req = 0;
    expect_take("R10 sync wins", 64'h0004_0200, 4'd4);
    go_level(2'd1, 1'b1, 3'b000, 64'h300);
    irq_req = 1; fiq_req = 1; serr_req = 1;
    @(negedge clk);
    irq_req = 0; fiq_req = 0; serr_req = 0;
    expect_take("R10 serror wins", 64'h0004_0380, 4'd7);
    go_level(2'd1, 1'b1, 3'b000, 64'h300);
    irq_req = 1; fiq_req = 1;
    @(negedge clk);
    irq_req = 0; fiq_req = 0;
    expect_take("R10 fiq over irq", 64'h0004_0300, 4'd6);
    go_level(2'd1, 1'b1, 3'b000, 64'h300);
    irq_req = 1; eret_req = 1;
    @(negedge clk);
    irq_req = 0; eret_req = 0;
    expect_take("R10 irq over return", 64'h0004_0280, 4'd5);

    // R12 return at level 0 ignored
    go_level(2'd0, 1'b0, 3'b000, 64'h400);
    eret_req = 1;
    @(negedge clk);
    eret_req = 0;
    chk("R12 no redirect", 64'(redirect), 64'd0);
    chk("R12 level stays 0", 64'(cur_el), 64'd0);
    fault_pc = 64'h404;
    sync_flt = 1;
    @(negedge clk);
    sync_flt = 0;
    expect_take("R3 lower 64-bit", 64'h0004_0400, 4'd8);

    // R5 level 2 handles its own exceptions with its own base
    sysw(2'd0, 2'd2, 64'h0000_0001_0000_0800);
    go_level(2'd2, 1'b1, 3'b000, 64'h500);
    fault_pc = 64'h504;
    sync_flt = 1;
    @(negedge clk);
    sync_flt = 0;
    expect_take("R5 level 2 slot", 64'h0000_0001_0000_0A00, 4'd4);
    chk("R5 level 2 kept", 64'(cur_el), 64'd2);
    sysr(2'd1, 2'd2, rd);
    chk("R7 level 2 link", rd, 64'h504);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule